// File: doc/BRIEF.md
# Fractional multiply with rounding and saturation

This unit multiplies signed fixed-point fractions held in vector element lanes. Each lane carries a 64-bit slot, and the element width select decides whether the low 8, 16, 32 or all 64 bits of that slot form the operand. The two operands are multiplied at full double width. The product is then shifted right arithmetically by one less than the element width, so the result keeps the fractional format of the inputs. A rounding increment, chosen by a 2-bit mode, is added to the shifted value. Finally the result is clamped to the signed range of the element.

The second operand comes from one of two places. It is either each lane's own value, or a single scalar that is broadcast to every lane. All lanes compute in parallel, and one register stage holds the results. A per-operation saturation pulse reports that at least one lane was clamped. A sticky flag collects those pulses until software clears it.

Top module: `fxmul_rs`

## Requirements
- R1: After reset, `vld_o`, `sat_o` and `sticky_o` are 0 and `res_o` is all zeros.
- R2: `vld_o` equals `vld_i` delayed by one clock. `res_o` and `sat_o` are loaded only on cycles where `vld_i` is 1, and `res_o` holds its value otherwise.
- R3: `ew_i` selects the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Only the low width bits of each operand slot are used, read as signed two's complement. Each lane result is sign-extended to fill its 64-bit slot.
- R4: The full signed product is shifted right arithmetically by (width − 1). With `rm_i` = 2 nothing is added, which truncates toward minus infinity.
- R5: With `rm_i` = 0, the most significant discarded bit is added, which rounds to nearest with ties going up.
- R6: With `rm_i` = 1, the unit rounds to nearest with ties going to even. The increment is the top discarded bit ANDed with (any lower discarded bit OR the kept LSB).
- R7: With `rm_i` = 3, the unit rounds to odd. The increment is 1 when the kept LSB is 0 and any discarded bit is 1.
- R8: A rounded value above the largest signed value of the width is replaced by that maximum. This includes most-negative times most-negative at every width, and the 64-bit case.
- R9: When `scalar_i` is 1, `s_i` replaces every lane's B operand. When it is 0, lane k uses `b_i[64k+63:64k]`.
- R10: `sat_o` is 1 in the output cycle of an operation where any lane was clamped, and 0 otherwise.
- R11: `sticky_o` is set by every saturating operation and stays set until `clr_i` is asserted. If a clear and a saturating operation arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Operation valid |
| ew_i | input | 2 | Element width select |
| rm_i | input | 2 | Rounding mode |
| scalar_i | input | 1 | Broadcast `s_i` as the B operand |
| a_i | input | LANES*64 | Operand A, one 64-bit slot per lane |
| b_i | input | LANES*64 | Operand B, one 64-bit slot per lane |
| s_i | input | 64 | Scalar B operand |
| clr_i | input | 1 | Clear the sticky saturation flag |
| vld_o | output | 1 | Result valid |
| res_o | output | LANES*64 | Lane results, sign-extended |
| sat_o | output | 1 | Saturation pulse for this operation |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with LANES = 3. This means one broadcast operation shows whether a scalar really reaches every lane, including a middle lane and not only the first and last. With three lanes, a clamp in any single lane also has to raise the shared saturation pulse. Random operands fill all 64 bits of every slot at every width. This way, stray upper bits that should be ignored are exercised at 8, 16 and 32 bits. Because the reference arithmetic is 128 bits wide, the 64-bit overflow case can be checked against an exact value.

// File: rtl/fxmul_rs.sv
module fxmul_rs #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld_i,
  input  logic [1:0]            ew_i,
  input  logic [1:0]            rm_i,
  input  logic                  scalar_i,
  input  logic [LANES*64-1:0]   a_i,
  input  logic [LANES*64-1:0]   b_i,
  input  logic [63:0]           s_i,
  input  logic                  clr_i,
  output logic                  vld_o,
  output logic [LANES*64-1:0]   res_o,
  output logic                  sat_o,
  output logic                  sticky_o
);
  localparam int DW = 64;

  function automatic logic [DW:0] fmul(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                       input logic [1:0] ew, input logic [1:0] rm);
    logic [6:0]            w;
    logic [6:0]            up;
    logic signed [DW-1:0]  sa, sb;
    logic signed [127:0]   p, q, r, mx, mn;
    logic [127:0]          lo;
    logic                  d, rest, inc;
    w  = 7'd8 << ew;
    up = 7'd64 - w;
    sa = $signed(a << up) >>> up;
    sb = $signed(b << up) >>> up;
    p  = $signed({{DW{sa[DW-1]}}, sa}) * $signed({{DW{sb[DW-1]}}, sb});
    q  = p >>> (w - 7'd1);
    lo = p & ((128'd1 << (w - 7'd1)) - 128'd1);
    d    = lo[w - 7'd2];
    rest = |(lo & ((128'd1 << (w - 7'd2)) - 128'd1));
    case (rm)
      2'd0:    inc = d;
      2'd1:    inc = d & (rest | q[0]);
      2'd2:    inc = 1'b0;
      default: inc = ~q[0] & (d | rest);
    endcase
    r  = q + $signed({127'd0, inc});
    mx = (128'sd1 <<< (w - 7'd1)) - 128'sd1;
    mn = ~mx;
    if (r > mx)      return {1'b1, mx[DW-1:0]};
    else if (r < mn) return {1'b1, mn[DW-1:0]};
    else             return {1'b0, r[DW-1:0]};
  endfunction

  logic [LANES*64-1:0] res_d;
  logic [LANES-1:0]    lsat;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DW:0] o;
    assign o = fmul(a_i[k*DW +: DW], scalar_i ? s_i : b_i[k*DW +: DW], ew_i, rm_i);
    assign res_d[k*DW +: DW] = o[DW-1:0];
    assign lsat[k]           = o[DW];
  end

  wire any_sat = vld_i & (|lsat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o    <= 1'b0;
      res_o    <= '0;
      sat_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      vld_o    <= vld_i;
      sticky_o <= (sticky_o & ~clr_i) | any_sat;
      if (vld_i) begin
        res_o <= res_d;
        sat_o <= |lsat;
      end else begin
        sat_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fxmul_rs_chk.sv
module fxmul_rs_chk #(
  parameter int LANES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                vld_i,
  input logic                clr_i,
  input logic                vld_o,
  input logic [LANES*64-1:0] res_o,
  input logic                sat_o,
  input logic                sticky_o
);
  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o == $past(vld_i)); // R2
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(res_o)); // R2
  AST_PULSE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> vld_o); // R10
  AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> sticky_o); // R11
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_o && !clr_i) |=> sticky_o); // R11
  AST_STICKY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_o) |-> sat_o); // R11
endmodule

bind fxmul_rs fxmul_rs_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .clr_i(clr_i), .vld_o(vld_o),
  .res_o(res_o), .sat_o(sat_o), .sticky_o(sticky_o)
);

// File: tb/fxmul_rs_bench.sv
`timescale 1ns/1ps
module fxmul_rs_bench;
  localparam int L = 3;
  logic clk = 0, rst_n = 0, vld_i = 0, scalar_i = 0, clr_i = 0;
  logic [1:0] ew_i = 0, rm_i = 0;
  logic [L*64-1:0] a_i = '0, b_i = '0;
  logic [63:0] s_i = '0;
  logic vld_o, sat_o, sticky_o;
  logic [L*64-1:0] res_o;
  int checks = 0, errors = 0;
  logic exp_st = 0;
  logic [L*64-1:0] exp_res = '0;

  always #2.5 clk = ~clk;

  fxmul_rs #(.LANES(L)) u_fxmul_rs (.clk(clk), .rst_n(rst_n), .vld_i(vld_i), .ew_i(ew_i),
    .rm_i(rm_i), .scalar_i(scalar_i), .a_i(a_i), .b_i(b_i), .s_i(s_i), .clr_i(clr_i),
    .vld_o(vld_o), .res_o(res_o), .sat_o(sat_o), .sticky_o(sticky_o));

  function automatic logic signed [127:0] sx(input logic [63:0] v, input logic [1:0] ew);
    case (ew)
      2'd0: return 128'($signed(v[7:0]));
      2'd1: return 128'($signed(v[15:0]));
      2'd2: return 128'($signed(v[31:0]));
      default: return 128'($signed(v));
    endcase
  endfunction

  function automatic logic [64:0] ref_op(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] ew, input logic [1:0] rm);
    int w;
    logic signed [127:0] p, q, rem, half, hi, lo_lim;
    logic up;
    w = 8 << ew;
    p = sx(a, ew) * sx(b, ew);
    q = p >>> (w - 1);
    rem = p - (q <<< (w - 1));
    half = 128'sd1 <<< (w - 2);
    case (rm)
      2'd0: up = rem >= half;
      2'd1: up = (rem > half) || (rem == half && q[0]);
      2'd2: up = 0;
      default: up = (rem != 0) && !q[0];
    endcase
    q = q + (up ? 128'sd1 : 128'sd0);
    hi = (128'sd1 <<< (w - 1)) - 1;
    lo_lim = -(128'sd1 <<< (w - 1));
    if (q > hi) return {1'b1, hi[63:0]};
    if (q < lo_lim) return {1'b1, lo_lim[63:0]};
    return {1'b0, q[63:0]};
  endfunction

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic [1:0] ew, input logic [1:0] rm,
                    input logic sc, input logic [L*64-1:0] a, input logic [L*64-1:0] b,
                    input logic [63:0] s, input logic clr);
    logic any = 0;
    @(negedge clk);
    vld_i = 1; ew_i = ew; rm_i = rm; scalar_i = sc; a_i = a; b_i = b; s_i = s; clr_i = clr;
    for (int k = 0; k < L; k++) begin
      logic [64:0] o;
      o = ref_op(a[k*64 +: 64], sc ? s : b[k*64 +: 64], ew, rm);
      exp_res[k*64 +: 64] = o[63:0];
      any |= o[64];
    end
    exp_st = (exp_st & ~clr) | any;
    @(negedge clk);
    vld_i = 0; clr_i = 0;
    chk({req, " res"}, res_o, exp_res);
    chk("R10 sat", sat_o, any);
    chk("R11 sticky", sticky_o, exp_st);
    chk("R2 valid", vld_o, 1);
  endtask

  task automatic clear_only();
    @(negedge clk); clr_i = 1; exp_st = 0;
    @(negedge clk); clr_i = 0;
    chk("R11 clear", sticky_o, 0);
    chk("R2 hold", res_o, exp_res);
    chk("R10 no pulse", sat_o, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] mneg [4];
    void'($urandom(32'h5eed));
    mneg[0] = 64'h80; mneg[1] = 64'h8000; mneg[2] = 64'h8000_0000; mneg[3] = 64'h8000_0000_0000_0000;
    repeat (3) @(negedge clk);
    chk("R1 res", res_o, '0);
    chk("R1 flags", {vld_o, sat_o, sticky_o}, 0);
    rst_n = 1;
    // ties and near-ties at 8 bits: 3*64=192 (tie, odd kept), 5*64=320 (tie, even kept), 3*43=129
    for (int m = 0; m < 4; m++) begin
      op(m == 0 ? "R5" : m == 1 ? "R6" : m == 2 ? "R4" : "R7", 0, 2'(m), 0,
         {64'd3, 64'd5, 64'd3}, {64'd64, 64'd64, 64'd43}, 0, 0);
      op(m == 0 ? "R5" : m == 1 ? "R6" : m == 2 ? "R4" : "R7", 1, 2'(m), 0,
         {64'hffff_fffd, 64'h7, 64'hfff3}, {64'h4000, 64'hc000, 64'h0123}, 0, 0);
    end
    // most negative squared at each width, upper slot bits garbage
    for (int e = 0; e < 4; e++) begin
      op("R8", 2'(e), 2'(e), 0, {mneg[e], mneg[e] | 64'hAA00_0000_0000_0000 >> (e * 8), 64'd1},
         {mneg[e], mneg[e], 64'd1}, 0, 0);
      clear_only();
    end
    op("R8", 3, 0, 0, {64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
       {64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0001, 64'h7fff_ffff_ffff_ffff}, 0, 0);
    // broadcast
    op("R9", 2, 1, 1, {64'h1234_5678, 64'hdead_beef, 64'h8000_0000}, {L{64'h5555}}, 64'h8000_0000, 0);
    // clear and saturation together: set wins
    op("R11", 0, 0, 1, {64'h80, 64'h1, 64'h2}, '0, 64'h80, 1);
    // random
    for (int i = 0; i < 600; i++) begin
      logic [L*64-1:0] ra, rb;
      for (int k = 0; k < L; k++) begin
        ra[k*64 +: 64] = {$urandom, $urandom};
        rb[k*64 +: 64] = {$urandom, $urandom};
        if ($urandom % 8 == 0) ra[k*64 +: 64] = mneg[$urandom % 4];
        if ($urandom % 8 == 0) rb[k*64 +: 64] = mneg[$urandom % 4];
      end
      op("R3", 2'($urandom), 2'($urandom), 1'($urandom % 4 == 0), ra, rb, {$urandom, $urandom},
         1'($urandom % 10 == 0));
      if ($urandom % 20 == 0) clear_only();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule